// File: doc/BRIEF.md
# Low-Power Mode Entry Sequencer

This block decides when the system enters and leaves the Wait and Stop low-power modes, and in what order the clock generation system is shut down. It runs on the system clock. Requests from the processor core are taken on the next clock edge. The clock-gating enables it drives then fall one cycle after the mode has been entered. A Stop entry always follows the same order. The PLL is first shut down and switched to bypass, and only on the following cycle may the oscillator be asked to go to low power. The oscillator therefore never stops while the PLL still depends on it.

A fast-recovery option, sampled when Stop is entered, leaves the PLL and oscillator controls exactly as they were. The return to Run then needs no PLL lock time. A time-of-day select input holds the oscillator low-power request off at all times, because the time-of-day logic needs the oscillator clock. A wake event ends any low-power mode. The oscillator request drops at once, and the clock enables come back one cycle later. After a full Stop, the PLL stays shut down and bypassed until software releases it.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset, `mode` is 0 (Run), both clock enables are 1, and `pll_shutdown`, `pll_bypass` and `osc_lowpwr` are 0.
- R2: In Run, `stop_req` sets `mode` to 2 (Stop, PLL off) at the next edge, even when `wait_req` is also high. `wait_req` alone sets `mode` to 1 (Wait).
- R3: `core_clk_en` goes low one cycle after `mode` enters Wait or Stop. `periph_clk_en` goes low one cycle after `mode` enters Stop and stays high through Wait.
- R4: On a Stop entry with fast recovery clear, `pll_shutdown` and `pll_bypass` rise on the same edge that sets `mode` to 2. `osc_lowpwr` can rise only once `mode` is 3 (Stop, oscillator low), one cycle later.
- R5: If `fast_rec` is high on the cycle Stop is requested, that stop leaves `pll_shutdown` and `pll_bypass` unchanged and never raises `osc_lowpwr`.
- R6: While `tod_sel` is high, `osc_lowpwr` is 0 in the same cycle, whatever the mode.
- R7: After the block returns to Run, `pll_shutdown` and `pll_bypass` stay as they were until `pll_release` is high in a Run cycle with no `stop_req`. A `pll_release` in any other cycle has no effect.
- R8: `wake` in Wait or in either Stop state sets `mode` to 4 (Exit) at the next edge, and `osc_lowpwr` is 0 in that cycle. On the following edge `mode` returns to 0, and both clock enables are 1 one cycle after Exit was entered.
- R9: `wake` in Run has no effect. In Exit, `stop_req` and `wait_req` are ignored and `mode` always goes to 0.
- R10: Without `wake`, `mode` moves from 2 to 3 after exactly one cycle and then stays at 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stop_req | input | 1 | Stop request from the core |
| wait_req | input | 1 | Wait request from the core |
| wake | input | 1 | Wake/exit event |
| fast_rec | input | 1 | Fast stop recovery enable, sampled at Stop entry |
| tod_sel | input | 1 | Time-of-day prescaler uses the oscillator |
| pll_release | input | 1 | Software release of the PLL shutdown and bypass |
| mode | output | 3 | Current mode: 0 Run, 1 Wait, 2 Stop PLL off, 3 Stop oscillator low, 4 Exit |
| pll_shutdown | output | 1 | PLL shutdown request |
| pll_bypass | output | 1 | PLL bypass select |
| osc_lowpwr | output | 1 | Oscillator low-power request |
| core_clk_en | output | 1 | Core clock gating enable |
| periph_clk_en | output | 1 | Peripheral clock gating enable |

## Verification
The hardest case to reach is a Stop that begins while the PLL is still shut down from an earlier Stop that software has not yet released. It matters most when that Stop uses fast recovery, or when `tod_sel` changes while the block sits in the oscillator-low state. The stimulus therefore chains several Stops with no `pll_release` in between. It raises `fast_rec` on one of them and toggles `tod_sel` in the middle of another. It also sends `pll_release` during Wait and together with `stop_req` before the release that should take effect. A behavioural model tracks the mode, the PLL hold, the sampled fast-recovery bit and the enables, and every output is compared against it on every cycle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    LPM_RUN      = 3'd0,
    LPM_WAIT     = 3'd1,
    LPM_STOP_PLL = 3'd2,
    LPM_STOP_OSC = 3'd3,
    LPM_EXIT     = 3'd4
  } lpm_state_e;
endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic       wait_req,
  input  logic       wake,
  output lpm_state_e state_o,
  output logic       enter_stop_o
);
  lpm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LPM_RUN: begin
        if (stop_req)      state_d = LPM_STOP_PLL;
        else if (wait_req) state_d = LPM_WAIT;
      end
      LPM_WAIT:     if (wake) state_d = LPM_EXIT;
      LPM_STOP_PLL: state_d = wake ? LPM_EXIT : LPM_STOP_OSC;
      LPM_STOP_OSC: if (wake) state_d = LPM_EXIT;
      LPM_EXIT:     state_d = LPM_RUN;
      default:      state_d = LPM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LPM_RUN;
    else        state_q <= state_d;
  end

  assign state_o      = state_q;
  assign enter_stop_o = (state_q == LPM_RUN) && stop_req;

  assert_stop_priority_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LPM_RUN && stop_req && wait_req) |=> (state_q == LPM_STOP_PLL));

  assert_exit_returns_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LPM_EXIT) |=> (state_q == LPM_RUN));

  assert_stop_advance_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LPM_STOP_PLL && !wake) |=> (state_q == LPM_STOP_OSC));

  assert_wake_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != LPM_RUN && state_q != LPM_EXIT && wake) |=> (state_q == LPM_EXIT));
endmodule

// File: rtl/lpm_pll_ctl.sv
module lpm_pll_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_stop,
  input  logic in_run,
  input  logic fast_rec,
  input  logic pll_release,
  output logic pll_off_o,
  output logic fast_q_o
);
  logic pll_off_q, pll_off_d;
  logic fast_q, fast_d;
  logic fast_en;

  assign fast_en = enter_stop;

  always_comb begin
    pll_off_d = pll_off_q;
    if (enter_stop && !fast_rec)
      pll_off_d = 1'b1;
    else if (in_run && pll_release && !enter_stop)
      pll_off_d = 1'b0;
    fast_d = fast_en ? fast_rec : fast_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_off_q <= 1'b0;
      fast_q    <= 1'b0;
    end else begin
      pll_off_q <= pll_off_d;
      fast_q    <= fast_d;
    end
  end

  assign pll_off_o = pll_off_q;
  assign fast_q_o  = fast_q;

  assert_fast_keeps_pll_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_stop && fast_rec) |=> $stable(pll_off_q));
endmodule

// File: rtl/lpm_clk_ctl.sv
module lpm_clk_ctl
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  lpm_state_e state,
  input  logic       fast_q,
  input  logic       tod_sel,
  output logic       core_en_o,
  output logic       periph_en_o,
  output logic       osc_lowpwr_o
);
  logic core_en_q, core_en_d;
  logic periph_en_q, periph_en_d;
  logic in_stop;

  assign in_stop = (state == LPM_STOP_PLL) || (state == LPM_STOP_OSC);

  always_comb begin
    core_en_d   = (state == LPM_RUN) || (state == LPM_EXIT);
    periph_en_d = !in_stop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_en_q   <= 1'b1;
      periph_en_q <= 1'b1;
    end else begin
      core_en_q   <= core_en_d;
      periph_en_q <= periph_en_d;
    end
  end

  assign core_en_o    = core_en_q;
  assign periph_en_o  = periph_en_q;
  assign osc_lowpwr_o = (state == LPM_STOP_OSC) && !fast_q && !tod_sel;

  assert_wait_gates_core_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LPM_WAIT) |=> (!core_en_q && periph_en_q));

  assert_exit_restores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LPM_EXIT) |=> (core_en_q && periph_en_q));
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_req,
  input  logic              wait_req,
  input  logic              wake,
  input  logic              fast_rec,
  input  logic              tod_sel,
  input  logic              pll_release,
  output logic [MODE_W-1:0] mode,
  output logic              pll_shutdown,
  output logic              pll_bypass,
  output logic              osc_lowpwr,
  output logic              core_clk_en,
  output logic              periph_clk_en
);
  logic       rst_int_n;
  lpm_state_e state;
  logic       enter_stop;
  logic       pll_off;
  logic       fast_q;

  lpm_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  lpm_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .stop_req     (stop_req),
    .wait_req     (wait_req),
    .wake         (wake),
    .state_o      (state),
    .enter_stop_o (enter_stop)
  );

  lpm_pll_ctl u_pll (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .enter_stop  (enter_stop),
    .in_run      (state == LPM_RUN),
    .fast_rec    (fast_rec),
    .pll_release (pll_release),
    .pll_off_o   (pll_off),
    .fast_q_o    (fast_q)
  );

  lpm_clk_ctl u_clk (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .state        (state),
    .fast_q       (fast_q),
    .tod_sel      (tod_sel),
    .core_en_o    (core_clk_en),
    .periph_en_o  (periph_clk_en),
    .osc_lowpwr_o (osc_lowpwr)
  );

  assign mode         = state;
  assign pll_shutdown = pll_off;
  assign pll_bypass   = pll_off;

  assert_pll_before_osc_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    osc_lowpwr |-> (pll_shutdown && pll_bypass && $past(state == LPM_STOP_PLL || state == LPM_STOP_OSC)));

  assert_tod_blocks_osc_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    tod_sel |-> !osc_lowpwr);

  assert_pll_hold_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(pll_shutdown) |-> $past(state == LPM_RUN && pll_release && !stop_req));

  assert_exit_osc_off_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == LPM_EXIT) |-> !osc_lowpwr);
endmodule

// File: tb/lpm_sequencer_bench.sv
module lpm_sequencer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 1'b0, wait_req = 1'b0, wake = 1'b0;
  logic fast_rec = 1'b0, tod_sel = 1'b0, pll_release = 1'b0;
  logic [2:0] mode;
  logic pll_shutdown, pll_bypass, osc_lowpwr, core_clk_en, periph_clk_en;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int m_mode = 0;
  bit m_pll = 0, m_fast = 0, m_core = 1, m_periph = 1;

  always #10 clk = ~clk;

  lpm_sequencer u_lpm_sequencer (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wait_req(wait_req),
    .wake(wake), .fast_rec(fast_rec), .tod_sel(tod_sel), .pll_release(pll_release),
    .mode(mode), .pll_shutdown(pll_shutdown), .pll_bypass(pll_bypass),
    .osc_lowpwr(osc_lowpwr), .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en)
  );

  always @(posedge clk) begin
    int old_mode;
    bit enter;
    if (!rst_n) begin
      m_mode = 0; m_pll = 0; m_fast = 0; m_core = 1; m_periph = 1;
    end else begin
      old_mode = m_mode;
      enter = (old_mode == 0) && stop_req;
      if (enter) m_fast = fast_rec;
      if (enter && !fast_rec) m_pll = 1;
      else if (old_mode == 0 && pll_release && !stop_req) m_pll = 0;
      m_core   = (old_mode == 0) || (old_mode == 4);
      m_periph = !(old_mode == 2 || old_mode == 3);
      case (old_mode)
        0: m_mode = stop_req ? 2 : (wait_req ? 1 : 0);
        1: m_mode = wake ? 4 : 1;
        2: m_mode = wake ? 4 : 3;
        3: m_mode = wake ? 4 : 3;
        default: m_mode = 0;
      endcase
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // compare every output against the model on each falling edge
  always @(negedge clk) begin
    chk("R2 R8 R9 R10 mode", int'(mode), m_mode);
    chk("R4 R5 R7 pll_shutdown", int'(pll_shutdown), int'(m_pll));
    chk("R4 R7 pll_bypass", int'(pll_bypass), int'(m_pll));
    chk("R4 R5 R6 R8 osc_lowpwr", int'(osc_lowpwr),
        int'((m_mode == 3) && !m_fast && !tod_sel));
    chk("R3 R8 core_clk_en", int'(core_clk_en), int'(m_core));
    chk("R3 R8 periph_clk_en", int'(periph_clk_en), int'(m_periph));
  end

  task automatic cyc(input bit s, input bit w, input bit k, input bit f, input bit r);
    @(negedge clk); #2;
    stop_req = s; wait_req = w; wake = k; fast_rec = f; pll_release = r;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // R1: reset values
    @(negedge clk); #1;
    chk("R1 mode", int'(mode), 0);
    chk("R1 pll", int'(pll_shutdown | pll_bypass | osc_lowpwr), 0);
    chk("R1 enables", int'(core_clk_en & periph_clk_en), 1);

    // R9: wake in Run ignored
    cyc(0, 0, 1, 0, 0); idle(2);

    // R3: Wait gates only the core clock
    cyc(0, 1, 0, 0, 0); idle(4);
    cyc(0, 0, 1, 0, 0); idle(3);

    // R2 R4: stop and wait together -> stop wins
    cyc(1, 1, 0, 0, 0);
    @(negedge clk); #1;
    chk("R2 priority", int'(mode), 2);
    chk("R4 pll first", int'(pll_shutdown && !osc_lowpwr), 1);
    idle(3);
    // R9: requests at the wake/exit boundary
    cyc(0, 0, 1, 0, 0); cyc(1, 1, 0, 0, 0); idle(3);

    // R7: PLL held; release in Wait and with stop ignored
    cyc(0, 1, 0, 0, 0); cyc(0, 0, 0, 0, 1); cyc(0, 0, 1, 0, 1); idle(2);
    chk("R7 held", int'(pll_shutdown), 1);
    // R5: fast stop while PLL already off leaves it off
    cyc(1, 0, 0, 1, 0); idle(3); cyc(0, 0, 1, 0, 0); idle(2);
    cyc(1, 0, 0, 0, 1); idle(2); cyc(0, 0, 1, 0, 0); idle(2);
    cyc(0, 0, 0, 0, 1); idle(2);
    chk("R7 released", int'(pll_shutdown), 0);

    // R5: fast stop with PLL running
    cyc(1, 0, 0, 1, 0); idle(4); cyc(0, 0, 1, 0, 0); idle(3);

    // R6: tod select blocks the oscillator request, toggled in Stop
    tod_sel = 1'b1;
    cyc(1, 0, 0, 0, 0); idle(3);
    tod_sel = 1'b0; idle(2);
    @(negedge clk); #1;
    chk("R6 osc low when tod clear", int'(osc_lowpwr), 1);
    tod_sel = 1'b1; idle(2);
    cyc(0, 0, 1, 0, 0); tod_sel = 1'b0; idle(3);

    // R8 R10: wake while still in the PLL-off state
    cyc(0, 0, 0, 0, 1); idle(1);
    cyc(1, 0, 0, 0, 0); cyc(0, 0, 1, 0, 0); idle(4);
    cyc(0, 0, 0, 0, 1); idle(3);

    finish_run();
  end
endmodule